// File: doc/BRIEF.md
# Dual-Channel Tamper Detection Controller

The block watches two external tamper switch inputs and records, per channel, whether a tamper event has happened. Each channel is configured by its own set of bits: whether the switch is normally open or normally closed, which pin level counts as a trigger, whether the channel is armed, whether its events raise the shared interrupt, and whether a normally-closed channel should save power by looking at its pin only in a short window once per second. Each pin passes through a synchronizer before it is evaluated. A detected event latches a sticky flag and, when enabled, drives a shared active-low interrupt.

The flag of a channel can be cleared only by disarming it. While a flag is set the channel stops evaluating its pin, so a later event neither changes the flag nor raises the interrupt again until the channel is disarmed and armed again. The interrupt has three independent clear sources: a read of the flags, dropping the channel's interrupt enable, and assertion of the chip reset output. The sampling window is built from a system-clock counter that restarts on each 1 Hz tick. Sampling is skipped whenever the oscillator is reported as stopped.

Top module: `tamper_guard`

## Requirements
- R1: A pin that reaches its trigger level on an armed, continuously monitored channel sets that channel's flag on the third rising clock edge after the change, because of a two-stage synchronizer and the flag register.
- R2: Polarity bit `cfg_hi` = 0 makes a low pin level the trigger; `cfg_hi` = 1 makes a high pin level the trigger.
- R3: While `cfg_arm` of a channel is 0 its flag is 0 from the next clock edge on, and the flag never sets.
- R4: Once set, a flag stays set while `cfg_arm` stays 1, whatever the pin does.
- R5: A new tamper event on a channel whose `cfg_irq_en` bit is 1 drives `irq_n` low on the same edge that sets the flag; `irq_n` is the inverted OR of each channel's pending request gated by its own `cfg_irq_en`.
- R6: A pending request is cleared on the edge where `flag_rd` is 1, `rst_out` is 1, or the channel's `cfg_irq_en` is 0; a clear wins over an event on the same edge.
- R7: A one-cycle `tick_1hz` pulse makes `win_open` 1 for exactly `WIN_CYCLES` cycles, starting on the edge that samples the tick; a tick inside a window restarts the count.
- R8: A channel with `cfg_nopen` = 0 (normally closed), `cfg_duty` = 1 and `osc_run` = 1 evaluates its pin only on edges where `win_open` is 1.
- R9: With `osc_run` = 0, or `cfg_nopen` = 1 (normally open), the channel evaluates its pin on every edge regardless of `cfg_duty`.
- R10: While a flag is set the channel raises no further interrupt request; after `cfg_arm` goes to 0 and back to 1, a pin still at trigger level sets the flag again on the first edge with `cfg_arm` = 1.
- R11: After reset both flags are 0, `irq_n` is 1 and `win_open` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_arm | input | NUM_CH | Per-channel tamper enable; 0 clears the flag |
| cfg_irq_en | input | NUM_CH | Per-channel interrupt enable |
| cfg_nopen | input | NUM_CH | 1 = normally-open switch, 0 = normally-closed |
| cfg_hi | input | NUM_CH | Trigger level: 0 = low, 1 = high |
| cfg_duty | input | NUM_CH | Duty-cycled sampling request for normally-closed mode |
| pin_in | input | NUM_CH | Raw tamper pin levels (asynchronous) |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| osc_run | input | 1 | 1 while the oscillator runs |
| flag_rd | input | 1 | One-cycle strobe: flags register read |
| rst_out | input | 1 | Chip reset output is asserted |
| win_open | output | 1 | Sample window strobe |
| tamper_flag | output | NUM_CH | Sticky per-channel tamper flags |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The embedded assertions check on every cycle that a disarmed channel holds a clear flag, that a set flag persists while armed, that a new request always comes with a rising flag, that a sampled channel stays quiet outside the window, that a tick opens the window, and that any of the global clear strobes releases the interrupt. The exact three-edge latency, the re-arm behaviour with the pin still at trigger level, the fallback to continuous monitoring when the oscillator stops, and the per-channel interrupt-enable clear can only be shown by the bench scenarios, which compare every cycle of a random run and a set of directed cases with a reference model written from the requirements.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

   typedef struct packed {
      logic arm;
      logic irq_en;
      logic nopen;
      logic hi;
      logic duty;
   } chan_cfg_t;

endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tamper_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("tamper_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/tamper_window.sv
module tamper_window #(
   parameter int WIN_CYCLES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1hz,
   output logic win_open
);

   localparam int CW = $clog2(WIN_CYCLES + 1);

   if (WIN_CYCLES < 1) begin : g_bad_win
      $error("tamper_window: WIN_CYCLES must be at least 1");
   end

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain <= '0;
      else if (tick_1hz)
         remain <= CW'(WIN_CYCLES);
      else if (remain != '0)
         remain <= remain - 1'b1;
   end

   assign win_open = (remain != '0);

   // R7: a tick always opens the window on the next cycle
   p_win_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick_1hz |=> win_open);

   // R7: the window never grows without a tick
   p_win_no_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_1hz && remain != '0) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/tamper_chan.sv
module tamper_chan
   import tamper_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  chan_cfg_t cfg,
   input  logic      pin_s,
   input  logic      win_open,
   input  logic      osc_run,
   input  logic      irq_clr,
   output logic      flag,
   output logic      irq_req
);

   logic at_level;
   logic duty_mode;
   logic looking;
   logic event_now;
   logic clr_req;

   assign at_level  = (pin_s == cfg.hi);
   // sampling applies only to a normally-closed switch with a live oscillator
   assign duty_mode = cfg.duty & ~cfg.nopen & osc_run;
   assign looking   = cfg.arm & ~flag & (~duty_mode | win_open);
   assign event_now = looking & at_level;
   assign clr_req   = irq_clr | ~cfg.irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (!cfg.arm)
         flag <= 1'b0;
      else if (event_now)
         flag <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_req <= 1'b0;
      else if (clr_req)
         irq_req <= 1'b0;
      else if (event_now)
         irq_req <= 1'b1;
   end

   // R3: disarmed channel holds a clear flag
   p_flag_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.arm |=> !flag);

   // R4: a set flag persists while armed
   p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && cfg.arm) |=> flag);

   // R5 / R10: a new request only comes with a new detection
   p_req_with_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $rose(flag));

   // R8: sampled channel stays quiet outside the window
   p_sample_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.arm && !flag && cfg.duty && !cfg.nopen && osc_run && !win_open) |=> !flag);

endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
   import tamper_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int WIN_CYCLES  = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cfg_arm,
   input  logic [NUM_CH-1:0] cfg_irq_en,
   input  logic [NUM_CH-1:0] cfg_nopen,
   input  logic [NUM_CH-1:0] cfg_hi,
   input  logic [NUM_CH-1:0] cfg_duty,
   input  logic [NUM_CH-1:0] pin_in,
   input  logic              tick_1hz,
   input  logic              osc_run,
   input  logic              flag_rd,
   input  logic              rst_out,
   output logic              win_open,
   output logic [NUM_CH-1:0] tamper_flag,
   output logic              irq_n
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("tamper_guard: NUM_CH must be at least 1");
   end

   logic [NUM_CH-1:0] pin_s;
   logic [NUM_CH-1:0] req;
   logic              global_clr;

   assign global_clr = flag_rd | rst_out;

   tamper_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   tamper_window #(.WIN_CYCLES(WIN_CYCLES)) i_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_1hz (tick_1hz),
      .win_open (win_open)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      chan_cfg_t cfg_c;
      assign cfg_c = '{arm:    cfg_arm[c],
                       irq_en: cfg_irq_en[c],
                       nopen:  cfg_nopen[c],
                       hi:     cfg_hi[c],
                       duty:   cfg_duty[c]};
      tamper_chan i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg      (cfg_c),
         .pin_s    (pin_s[c]),
         .win_open (win_open),
         .osc_run  (osc_run),
         .irq_clr  (global_clr),
         .flag     (tamper_flag[c]),
         .irq_req  (req[c])
      );
   end

   assign irq_n = ~|(req & cfg_irq_en);

   // R6: a flags read or reset output releases the interrupt
   p_irq_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      global_clr |=> irq_n);

endmodule

// File: tb/test_tamper_guard.sv
module test_tamper_guard;

   localparam int  NC     = 2;
   localparam int  WIN    = 50;
   localparam time CLK_PERIOD = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] arm = '0, ien = '0, nopen = '0, hi = '0, duty = '0, pin = '0;
   logic          tick = 1'b0, osc = 1'b1, rd = 1'b0, rso = 1'b0;
   logic          win;
   logic [NC-1:0] flg;
   logic          irqn;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tamper_guard #(.NUM_CH(NC), .SYNC_STAGES(2), .WIN_CYCLES(WIN)) i_tamper_guard (
      .clk(clk), .rst_n(rst_n), .cfg_arm(arm), .cfg_irq_en(ien), .cfg_nopen(nopen),
      .cfg_hi(hi), .cfg_duty(duty), .pin_in(pin), .tick_1hz(tick), .osc_run(osc),
      .flag_rd(rd), .rst_out(rso), .win_open(win), .tamper_flag(flg), .irq_n(irqn)
   );

   // reference model built from the requirements
   logic [NC-1:0] m_s1, m_s2, m_flag, m_req;
   int            m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_flag <= '0; m_req <= '0; m_cnt <= 0;
      end else begin
         logic mwin;
         mwin = (m_cnt != 0);
         for (int c = 0; c < NC; c++) begin
            logic samp, ev;
            samp = duty[c] & ~nopen[c] & osc;
            ev = arm[c] & ~m_flag[c] & (~samp | mwin) & (m_s2[c] == hi[c]);
            m_flag[c] <= arm[c] ? (m_flag[c] | ev) : 1'b0;
            if (rd | rso | ~ien[c]) m_req[c] <= 1'b0;
            else if (ev)            m_req[c] <= 1'b1;
         end
         m_s1 <= pin;
         m_s2 <= m_s1;
         if (tick) m_cnt <= WIN;
         else if (m_cnt != 0) m_cnt <= m_cnt - 1;
      end
   end

   function automatic logic exp_irqn(logic [NC-1:0] r, logic [NC-1:0] e);
      return ~|(r & e);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // sample mid-cycle, compare against the model
   task automatic step(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk("R2 flags vs model", 32'(flg), 32'(m_flag));
         chk("R5 irq_n vs model", 32'(irqn), 32'(exp_irqn(m_req, ien)));
         chk("R7 win_open vs model", 32'(win), 32'(m_cnt != 0));
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 flags at reset", 32'(flg), 0);
      chk("R11 irq_n at reset", 32'(irqn), 1);
      chk("R11 win_open at reset", 32'(win), 0);
      rst_n = 1'b1;
      step(2);

      // R1 / R2 / R5: ch0 normally open, high trigger, continuous
      arm = 2'b01; ien = 2'b01; nopen = 2'b01; hi = 2'b01; duty = 2'b01; pin = 2'b00;
      step(3);
      pin[0] = 1'b1;
      step(2);
      chk("R1 flag not yet after two edges", 32'(flg[0]), 0);
      step(1);
      chk("R1 flag on third edge", 32'(flg[0]), 1);
      chk("R5 irq asserted with flag", 32'(irqn), 0);

      // R4 / R10: pin toggles, flag stays, no new request after read
      pin[0] = 1'b0;
      rd = 1'b1; step(1); rd = 1'b0;
      chk("R6 flags read clears irq", 32'(irqn), 1);
      pin[0] = 1'b1; step(5);
      chk("R4 flag sticky", 32'(flg[0]), 1);
      chk("R10 no new irq while flagged", 32'(irqn), 1);

      // R3 / R10: disarm then rearm with pin still at trigger level
      arm[0] = 1'b0; step(1);
      chk("R3 disarm clears flag", 32'(flg[0]), 0);
      step(2);
      chk("R3 flag stays clear while disarmed", 32'(flg[0]), 0);
      arm[0] = 1'b1; step(1);
      chk("R10 rearm detects at once", 32'(flg[0]), 1);
      chk("R10 rearm raises irq", 32'(irqn), 0);

      // R6: interrupt enable drop and reset output
      ien[0] = 1'b0; step(1);
      ien[0] = 1'b1; step(1);
      chk("R6 irq_en drop clears request", 32'(irqn), 1);
      arm[0] = 1'b0; step(1); arm[0] = 1'b1; step(1);
      chk("R6 setup irq pending", 32'(irqn), 0);
      rso = 1'b1; step(1); rso = 1'b0;
      chk("R6 reset output clears irq", 32'(irqn), 1);

      // R8: ch1 normally closed, low trigger, sampled, oscillator running
      arm = 2'b10; ien = 2'b10; nopen = 2'b00; hi = 2'b00; duty = 2'b10; pin = 2'b00;
      osc = 1'b1;
      step(WIN + 2);
      arm[1] = 1'b1; step(6);
      chk("R8 no detection outside window", 32'(flg[1]), 0);
      tick = 1'b1; step(1); tick = 1'b0;
      chk("R7 window opens after tick", 32'(win), 1);
      step(1);
      chk("R8 detection inside window", 32'(flg[1]), 1);
      step(WIN);
      chk("R7 window closed after WIN_CYCLES", 32'(win), 0);

      // R9: oscillator stopped -> continuous
      arm[1] = 1'b0; step(1); osc = 1'b0; arm[1] = 1'b1; step(1);
      chk("R9 osc stopped gives continuous check", 32'(flg[1]), 1);
      osc = 1'b1;
      // R9: normally open ignores the duty bit
      arm[1] = 1'b0; step(1); nopen[1] = 1'b1; arm[1] = 1'b1; step(1);
      chk("R9 normally open ignores duty bit", 32'(flg[1]), 1);

      // random phase, checked every cycle against the model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         chk("R2 flags vs model", 32'(flg), 32'(m_flag));
         chk("R5 irq_n vs model", 32'(irqn), 32'(exp_irqn(m_req, ien)));
         chk("R7 win_open vs model", 32'(win), 32'(m_cnt != 0));
         if ($urandom_range(0, 15) == 0) arm   = 2'($urandom);
         if ($urandom_range(0, 31) == 0) ien   = 2'($urandom);
         if ($urandom_range(0, 63) == 0) nopen = 2'($urandom);
         if ($urandom_range(0, 63) == 0) hi    = 2'($urandom);
         if ($urandom_range(0, 63) == 0) duty  = 2'($urandom);
         if ($urandom_range(0, 7)  == 0) pin   = 2'($urandom);
         if ($urandom_range(0, 127) == 0) osc  = ~osc;
         tick = ($urandom_range(0, 59) == 0);
         rd   = ($urandom_range(0, 23) == 0);
         rso  = ($urandom_range(0, 79) == 0);
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule